// File: doc/BRIEF.md
# Descrambler Synchronization Timeout Monitor

This block watches a 100 Mb/s receive descrambler while it reports lock. It runs an interval timer over the locked cycles and counts the received IDLE symbols that fall inside each interval. When an interval closes with fewer IDLEs than a set minimum, the block raises a single-cycle restart request that sends the descrambler back to its IDLE search, and it sets a sticky loss-of-synchronization flag.

Two interval lengths are available: 722 µs for standard frame sizes, and 2 ms for links that carry frames longer than standard Ethernet. A disable control stops supervision altogether. All pins are plain control and status levels or pulses. No data stream passes through, so there is no valid/ready handshake and no back-pressure. Time is measured in clock cycles through the `CYC_PER_US` parameter.

Top module: `dsync_watchdog`

## Requirements
- R1: After reset `restart_o` and `sync_lost_o` are 0, and the latched window choice is the short (722 µs) window.
- R2: With the short window latched, an interval spans exactly 722*CYC_PER_US cycles in which `lock_i`=1 and `to_dis_i`=0. If fewer than MIN_IDLES `idle_i` pulses fall in those cycles, counting the final cycle, `restart_o` is 1 in the cycle after the final one.
- R3: With the long window latched, an interval spans exactly 2000*CYC_PER_US such cycles.
- R4: An interval that holds MIN_IDLES or more IDLE pulses, wherever they sit in it (the final cycle included), produces no restart. MIN_IDLES-1 pulses do produce one.
- R5: `restart_o` is never high for two consecutive cycles.
- R6: `sync_lost_o` rises together with `restart_o`. It stays 1 until `lock_i` goes from 0 to 1, and it is 0 in the cycle after that rising edge.
- R7: While `lock_i` is 0, the timer and the IDLE count are held at zero and no restart occurs. After lock returns, a full fresh interval must pass before the next restart.
- R8: While `to_dis_i` is 1, no restart occurs, and the timer and the count are held at zero. When it returns to 0, a full fresh interval starts.
- R9: `long_win_i` is sampled at interval boundaries and in every cycle in which the timer is held. A change in the middle of an interval does not alter that interval's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Descrambler reports lock |
| idle_i | input | 1 | One-cycle pulse per received IDLE symbol |
| long_win_i | input | 1 | 1 selects the 2 ms window, 0 selects the 722 µs window |
| to_dis_i | input | 1 | 1 stops the timeout supervision |
| restart_o | output | 1 | One-cycle request to restart the IDLE search |
| sync_lost_o | output | 1 | Sticky loss-of-synchronization flag |

## Verification
Directed windows place no IDLEs, MIN_IDLES-1 IDLEs, MIN_IDLES IDLEs at the head of the interval, and MIN_IDLES IDLEs at its tail. These separate an off-by-one in the threshold from one in the interval length, and they show whether the final cycle's IDLE is counted. Runs with the long window, with the select bit flipped mid-interval, with lock dropped mid-interval, and with the disable bit held, tell the boundary-sampled window choice and the hold-at-zero rule apart from a free-running timer. A random phase then varies lock, disable, select and IDLE density, and the bench's own model of the requirements checks it cycle by cycle.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  function automatic int win_cycles(input int us, input int cyc_per_us);
    return us * cyc_per_us;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dsync_interval_timer.sv
module dsync_interval_timer
  import dsync_pkg::*;
#(
  parameter int CYC_PER_US = 1,
  parameter int SHORT_US   = 722,
  parameter int LONG_US    = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic long_win_i,
  output logic boundary_o
);
  localparam int LIM_S   = win_cycles(SHORT_US, CYC_PER_US);
  localparam int LIM_L   = win_cycles(LONG_US, CYC_PER_US);
  localparam int LIM_MAX = max_int(LIM_S, LIM_L);
  localparam int TW      = $clog2(LIM_MAX + 1);

  logic [TW-1:0] tmr_q;
  logic [TW-1:0] last_tick;
  logic          long_q;

  // last cycle of the interval for the latched window choice
  assign last_tick  = long_q ? TW'(LIM_L - 1) : TW'(LIM_S - 1);
  assign boundary_o = run_i && (tmr_q == last_tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      long_q <= 1'b0;
    end else if (!run_i) begin
      tmr_q  <= '0;
      long_q <= long_win_i;
    end else if (boundary_o) begin
      tmr_q  <= '0;
      long_q <= long_win_i;
    end else begin
      tmr_q  <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsync_idle_tally.sv
module dsync_idle_tally #(
  parameter int MIN_IDLES = 29
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic idle_i,
  input  logic boundary_i,
  output logic short_o
);
  localparam int CW = $clog2(MIN_IDLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_now;

  // count including this cycle's IDLE, one bit wider so it cannot wrap
  assign cnt_now = {1'b0, cnt_q} + (CW+1)'(idle_i);
  assign short_o = cnt_now < (CW+1)'(MIN_IDLES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || boundary_i) begin
      cnt_q <= '0;
    end else if (idle_i && (cnt_q != CW'(MIN_IDLES))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsync_loss_ctrl.sv
module dsync_loss_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic boundary_i,
  input  logic short_i,
  output logic restart_o,
  output logic sync_lost_o
);
  logic lock_d;
  logic lock_rise;
  logic expire;

  assign lock_rise = lock_i && !lock_d;
  assign expire    = boundary_i && short_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_d      <= 1'b0;
      restart_o   <= 1'b0;
      sync_lost_o <= 1'b0;
    end else begin
      lock_d    <= lock_i;
      restart_o <= expire;
      if (lock_rise)   sync_lost_o <= 1'b0;
      else if (expire) sync_lost_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dsync_watchdog.sv
module dsync_watchdog #(
  parameter int CYC_PER_US = 1,
  parameter int SHORT_US   = 722,
  parameter int LONG_US    = 2000,
  parameter int MIN_IDLES  = 29
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic idle_i,
  input  logic long_win_i,
  input  logic to_dis_i,
  output logic restart_o,
  output logic sync_lost_o
);
  logic run;
  logic boundary;
  logic short_cnt;

  assign run = lock_i && !to_dis_i;

  dsync_interval_timer #(
    .CYC_PER_US(CYC_PER_US),
    .SHORT_US  (SHORT_US),
    .LONG_US   (LONG_US)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .long_win_i(long_win_i),
    .boundary_o(boundary)
  );

  dsync_idle_tally #(
    .MIN_IDLES(MIN_IDLES)
  ) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .idle_i    (idle_i),
    .boundary_i(boundary),
    .short_o   (short_cnt)
  );

  dsync_loss_ctrl u_loss (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_i     (lock_i),
    .boundary_i (boundary),
    .short_i    (short_cnt),
    .restart_o  (restart_o),
    .sync_lost_o(sync_lost_o)
  );
endmodule

// File: rtl/dsync_watchdog_sva.sv
module dsync_watchdog_sva (
  input logic clk,
  input logic rst_n,
  input logic lock_i,
  input logic to_dis_i,
  input logic restart_o,
  input logic sync_lost_o
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);

  a_r6_flag_with_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> sync_lost_o);

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lost_o && !$rose(lock_i)) |=> sync_lost_o);

  a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_i) |=> !sync_lost_o);

  a_r7_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> !restart_o);

  a_r8_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    to_dis_i |=> !restart_o);
endmodule

bind dsync_watchdog dsync_watchdog_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .lock_i     (lock_i),
  .to_dis_i   (to_dis_i),
  .restart_o  (restart_o),
  .sync_lost_o(sync_lost_o)
);

// File: tb/dsync_watchdog_bench.sv
module dsync_watchdog_bench;
  localparam int CPU   = 1;
  localparam int MINI  = 29;
  localparam int LIM_S = 722 * CPU;
  localparam int LIM_L = 2000 * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_i = 1'b0, idle_i = 1'b0, long_win_i = 1'b0, to_dis_i = 1'b0;
  logic restart_o, sync_lost_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dsync_watchdog #(.CYC_PER_US(CPU), .MIN_IDLES(MINI)) u_dsync_watchdog (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .idle_i(idle_i),
    .long_win_i(long_win_i), .to_dis_i(to_dis_i),
    .restart_o(restart_o), .sync_lost_o(sync_lost_o)
  );

  // reference model built from the requirements
  int m_t, m_c; bit m_sel, m_rst, m_lost, m_lockd;

  function automatic int lim_of(bit sel);
    return sel ? LIM_L : LIM_S;
  endfunction

  always @(posedge clk) begin
    bit run, bnd, shrt;
    if (!rst_n) begin
      m_t = 0; m_c = 0; m_sel = 0; m_rst = 0; m_lost = 0; m_lockd = 0;
    end else begin
      run  = lock_i && !to_dis_i;
      bnd  = run && (m_t == lim_of(m_sel) - 1);
      shrt = (m_c + int'(idle_i)) < MINI;
      m_rst = bnd && shrt;
      if (lock_i && !m_lockd) m_lost = 0;
      else if (bnd && shrt)   m_lost = 1;
      m_lockd = lock_i;
      if (!run || bnd) begin
        m_t = 0; m_c = 0; m_sel = long_win_i;
      end else begin
        m_t++; if (idle_i) m_c++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model (R2 R3 R5 R6)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model restart_o", int'(restart_o), int'(m_rst));
      check("R6 model sync_lost_o", int'(sync_lost_o), int'(m_lost));
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int until_restart_dummy();
    return 0;
  endfunction

  // counts negedges until restart_o is seen; -1 if not within max
  task automatic count_to_restart(input int max, output int n);
    n = -1;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (restart_o) begin n = i; return; end
    end
  endtask

  // one fresh window: unlock, then k IDLEs at head (or tail), sel possibly flipped at flip_at
  task automatic window(input string req, input int k, input bit sel, input bit tail,
                        input int flip_at, input bit exp);
    int lim; bit early;
    lim = lim_of(sel);
    @(negedge clk); lock_i = 0; idle_i = 0; long_win_i = sel;
    cycles(3);
    early = 0;
    for (int i = 0; i < lim; i++) begin
      if (i > 0) begin
        @(negedge clk);
        if (restart_o) early = 1;
      end
      lock_i = 1;
      idle_i = tail ? (i >= lim - k) : (i < k);
      if (i == flip_at) long_win_i = ~sel;
    end
    @(negedge clk); idle_i = 0;
    check({req, " no early restart"}, int'(early), 0);
    check({req, " restart at boundary"}, int'(restart_o), int'(exp));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    int n;
    void'($urandom(32'd1234));
    cycles(4);
    rst_n = 1;
    @(negedge clk);
    check("R1 restart_o after reset", int'(restart_o), 0);
    check("R1 sync_lost_o after reset", int'(sync_lost_o), 0);

    // R1 + R2: short window is latched by default; restart exactly after 722 cycles
    lock_i = 1;
    count_to_restart(LIM_L + 10, n);
    check("R1 R2 first window length", n, LIM_S);
    check("R6 flag set with restart", int'(sync_lost_o), 1);
    @(negedge clk);
    check("R5 restart one cycle", int'(restart_o), 0);
    cycles(100);
    check("R6 flag held while locked", int'(sync_lost_o), 1);
    lock_i = 0; cycles(5);
    check("R6 flag held while unlocked", int'(sync_lost_o), 1);
    lock_i = 1; @(negedge clk);
    check("R6 flag clears after lock rise", int'(sync_lost_o), 0);

    // R4 thresholds and final-cycle IDLE
    window("R4 no idles", 0, 0, 0, -1, 1);
    window("R4 min-1 idles", MINI - 1, 0, 0, -1, 1);
    window("R4 min idles head", MINI, 0, 0, -1, 0);
    window("R4 min idles tail", MINI, 0, 1, -1, 0);
    window("R4 min-1 idles tail", MINI - 1, 0, 1, -1, 1);

    // R3 long window
    window("R3 long window", 0, 1, 0, -1, 1);

    // R9: flip to long mid-window keeps 722; next interval then uses 2000
    window("R9 flip mid short window", 0, 0, 0, 100, 1);
    count_to_restart(LIM_L + 10, n);
    check("R9 next window uses new select", n, LIM_L);
    long_win_i = 0;
    count_to_restart(LIM_L + 10, n);
    check("R9 long interval ends before short applies", n, LIM_L);
    count_to_restart(LIM_L + 10, n);
    check("R9 short applies at following window", n, LIM_S);

    // R7: unlock holds the timer at zero
    lock_i = 0; cycles(3000);
    check("R7 no restart while unlocked", int'(restart_o), 0);
    lock_i = 1; cycles(500);
    lock_i = 0; cycles(10);
    lock_i = 1;
    count_to_restart(LIM_L, n);
    check("R7 fresh window after relock", n, LIM_S);

    // R8: disable holds everything
    to_dis_i = 1;
    count_to_restart(3000, n);
    check("R8 no restart while disabled", n, -1);
    to_dis_i = 0;
    count_to_restart(LIM_L, n);
    check("R8 fresh window after enable", n, LIM_S);

    // random phase, checked against the model
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 1999) == 0) lock_i = ~lock_i;
      if ($urandom_range(0, 4999) == 0) to_dis_i = ~to_dis_i;
      if ($urandom_range(0, 2999) == 0) long_win_i = ~long_win_i;
      idle_i = ($urandom_range(0, 999) < 38);
    end

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule